// File: doc/BRIEF.md
# Four-Channel Register Bank with Broadcast Select

This block is the register file of a four-channel device. One simple register bus reaches it: an 8-bit address, 8-bit write data, a write strobe, a read strobe and registered read data. A small set of shared control and status registers serves the whole device. Each of the four channels also has its own private 256-byte register set.

A select register at the top address (0xFF) steers each access. It can send an access to the shared set or to one chosen channel. For writes it can also broadcast to all four channel sets in a single cycle. Writes to 0xFF always land in the select register, whatever its current value, so software can always regain control of the steering.

The shared set holds the following fields:
- A read-only bus address formed from a 4-bit strap input.
- A scratch register.
- A self-clearing soft-reset command.
- Four sticky per-channel interrupt flags, fed by plain event inputs.

Top module: `chanreg_bank`

## Requirements
- R1: After the asynchronous reset, `rdata` is 0x00. The select register, the scratch register, the interrupt flags and every channel byte read back 0x00.
- R2: A write to 0xFF always loads `wdata[3:0]` into the select register, whatever its current value. A read of 0xFF always returns `{4'b0000, select}`, so bits 7:4 read 0. Select fields: bit 3 is broadcast, bit 2 is channel enable, and bits 1:0 are the channel number.
- R3: With select bit 2 = 1 and bit 3 = 0, a write to any address other than 0xFF updates only the channel chosen by bits 1:0. The other channels and the shared set are unchanged.
- R4: With select bits 3 and 2 both 1, a write to any address other than 0xFF updates that byte in all four channel sets in the same cycle. This stays in force until bit 3 or bit 2 is cleared. With bit 3 = 1 and bit 2 = 0, writes go to the shared set.
- R5: With select bit 2 = 1, a read of any address other than 0xFF returns that byte of the channel chosen by bits 1:0. With bit 2 = 0, it returns the shared set.
- R6: `rdata` takes the addressed value on the clock edge where `rd_en` is high. It holds its value on every edge where `rd_en` is low.
- R7: Shared address 0x00 reads `8'h18 + {4'b0000, strap}`. Writes to it have no effect.
- R8: A shared write to 0x01 with `wdata[0]` = 1 clears the select register, the scratch register and the interrupt flags. Address 0x01 always reads 0x00.
- R9: Shared address 0x04 reads `{4'b0000, flags}`, where flag bit i is set on any clock edge where `irq_evt[i]` is high. A flag stays set until the R8 clear. An event in the same cycle as the clear leaves the flag set. Writes to 0x04 have no effect.
- R10: Shared address 0x02 is an 8-bit read/write scratch register.
- R11: Every shared address other than 0x00, 0x01, 0x02, 0x04 and 0xFF reads 0x00, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; data appears on `rdata` after the next edge |
| rdata | output | 8 | Registered read data |
| strap | input | 4 | Strap value added to the base bus address 0x18 |
| irq_evt | input | 4 | Per-channel interrupt events, one bit per channel |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle, since a broadcast write together with a read is not allowed. They also assume that `strap` does not change in the cycle of a read to address 0x00.

The bench issues every access through tasks that raise exactly one strobe for one cycle. It changes `strap` only between accesses. The random phase draws select values, addresses and data freely, and a bench model follows each write, including broadcasts and soft clears, to predict every read.

// File: rtl/chanreg_pkg.sv
package chanreg_pkg;
  localparam int unsigned AW   = 8;
  localparam int unsigned DW   = 8;
  localparam int unsigned CHW  = 2;
  localparam int unsigned NCH  = 1 << CHW;
  localparam int unsigned SELW = CHW + 2;

  localparam logic [AW-1:0] A_BUSADR  = 8'h00;
  localparam logic [AW-1:0] A_CTRL    = 8'h01;
  localparam logic [AW-1:0] A_SCRATCH = 8'h02;
  localparam logic [AW-1:0] A_IRQ     = 8'h04;
  localparam logic [AW-1:0] A_SEL     = 8'hFF;

  localparam logic [DW-1:0] BUS_BASE  = 8'h18;
  localparam int unsigned   CLR_BIT   = 0;

  typedef struct packed {
    logic           all;
    logic           en;
    logic [CHW-1:0] ch;
  } sel_t;
endpackage

// File: rtl/chanreg_chan.sv
module chanreg_chan #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/chanreg_shared.sv
module chanreg_shared
  import chanreg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [3:0]     strap,
  input  logic [NCH-1:0] irq_evt,
  output sel_t           sel,
  output logic [NCH-1:0] irq_flags,
  output logic [DW-1:0]  sh_rdata
);
  sel_t           sel_q, sel_nxt;
  logic [DW-1:0]  scr_q, scr_nxt;
  logic [NCH-1:0] irq_q, irq_nxt;
  logic           wr_sel, wr_sh, soft_clr;
  logic           sel_ce, scr_ce, irq_ce;

  assign wr_sel   = wr_en && (addr == A_SEL);
  assign wr_sh    = wr_en && (addr != A_SEL) && !sel_q.en;
  assign soft_clr = wr_sh && (addr == A_CTRL) && wdata[CLR_BIT];

  assign sel_ce = wr_sel || soft_clr;
  assign scr_ce = soft_clr || (wr_sh && (addr == A_SCRATCH));
  assign irq_ce = soft_clr || (irq_evt != '0);

  always_comb begin
    sel_nxt = soft_clr ? '0 : sel_t'(wdata[SELW-1:0]);
    scr_nxt = soft_clr ? '0 : wdata;
    irq_nxt = (soft_clr ? '0 : irq_q) | irq_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      scr_q <= '0;
      irq_q <= '0;
    end else begin
      if (sel_ce) sel_q <= sel_nxt;
      if (scr_ce) scr_q <= scr_nxt;
      if (irq_ce) irq_q <= irq_nxt;
    end
  end

  always_comb begin
    unique case (addr)
      A_BUSADR:  sh_rdata = BUS_BASE + {{(DW-4){1'b0}}, strap};
      A_SCRATCH: sh_rdata = scr_q;
      A_IRQ:     sh_rdata = {{(DW-NCH){1'b0}}, irq_q};
      A_SEL:     sh_rdata = {{(DW-SELW){1'b0}}, sel_q};
      default:   sh_rdata = '0;
    endcase
  end

  assign sel       = sel_q;
  assign irq_flags = irq_q;
endmodule

// File: rtl/chanreg_bank.sv
module chanreg_bank
  import chanreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    addr,
  input  logic [7:0]    wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  input  logic [3:0]    strap,
  input  logic [3:0]    irq_evt
);
  sel_t           sel_cur;
  logic [NCH-1:0] irq_flags;
  logic [DW-1:0]  sh_rdata;
  logic [DW-1:0]  ch_rdata [NCH];
  logic [NCH-1:0] ch_we;
  logic [DW-1:0]  rd_nxt, rdata_q;
  logic           to_chan;

  chanreg_shared i_shared (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .strap     (strap),
    .irq_evt   (irq_evt),
    .sel       (sel_cur),
    .irq_flags (irq_flags),
    .sh_rdata  (sh_rdata)
  );

  assign to_chan = sel_cur.en && (addr != A_SEL);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign ch_we[c] = wr_en && to_chan && (sel_cur.all || (sel_cur.ch == CHW'(c)));

    chanreg_chan #(.AW(AW), .DW(DW)) i_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ch_we[c]),
      .addr  (addr),
      .wdata (wdata),
      .rdata (ch_rdata[c])
    );
  end

  always_comb begin
    rd_nxt = to_chan ? ch_rdata[sel_cur.ch] : sh_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_nxt;
    end
  end

  assign rdata = rdata_q;
endmodule

module chanreg_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic [3:0] strap,
  input logic [3:0] irq_evt,
  input logic [3:0] sel_w,
  input logic [3:0] irq_w
);
  logic clr_now;
  assign clr_now = wr_en && (addr == 8'h01) && !sel_w[2] && wdata[0];

  a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'hFF) |=> (sel_w == $past(wdata[3:0])));

  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  a_r7_busaddr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'h00 && !sel_w[2]) |=> (rdata == 8'h18 + {4'b0, $past(strap)}));

  a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt != 4'b0) |=> ((irq_w & $past(irq_evt)) == $past(irq_evt)));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_now |=> ((irq_w & $past(irq_w)) == $past(irq_w)));

  a_r8_clear_sel: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (sel_w == 4'b0));

  a_r11_rsvd_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_w[2] && addr != 8'h00 && addr != 8'h02 && addr != 8'h04 && addr != 8'hFF)
    |=> (rdata == 8'h00));
endmodule

bind chanreg_bank chanreg_bank_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wdata   (wdata),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rdata   (rdata),
  .strap   (strap),
  .irq_evt (irq_evt),
  .sel_w   (sel_cur),
  .irq_w   (irq_flags)
);

// File: tb/test_chanreg_bank.sv
`timescale 1ns/1ps
module test_chanreg_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic [3:0] strap = 4'h5;
  logic [3:0] irq_evt = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_ch [4][256];
  logic [7:0] m_scr;
  logic [3:0] m_sel;
  logic [3:0] m_irq;

  always #4 clk = ~clk;

  chanreg_bank i_chanreg_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .strap(strap), .irq_evt(irq_evt)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'hFF) return {4'b0, m_sel};
    if (m_sel[2]) return m_ch[m_sel[1:0]][a];
    case (a)
      8'h00: return 8'h18 + {4'b0, strap};
      8'h02: return m_scr;
      8'h04: return {4'b0, m_irq};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [3:0] ev = 4'b0);
    bit clr;
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; irq_evt = ev;
    clr = 1'b0;
    if (a == 8'hFF) m_sel = d[3:0];
    else if (m_sel[2]) begin
      for (int c = 0; c < 4; c++)
        if (m_sel[3] || m_sel[1:0] == 2'(c)) m_ch[c][a] = d;
    end else if (a == 8'h01 && d[0]) begin
      clr = 1'b1; m_scr = '0; m_sel = '0;
    end else if (a == 8'h02) m_scr = d;
    m_irq = (clr ? 4'b0 : m_irq) | ev;
    @(negedge clk);
    wr_en = 1'b0; irq_evt = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    e = exp_rd(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] hold;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) for (int a = 0; a < 256; a++) m_ch[c][a] = '0;
    m_scr = '0; m_sel = '0; m_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 rdata after reset", rdata, 8'h00);
    rd_chk("R1 select reset", 8'hFF);
    rd_chk("R1 scratch reset", 8'h02);
    rd_chk("R1 irq reset", 8'h04);
    wr(8'hFF, 8'h07);
    rd_chk("R1 channel byte reset", 8'h33);
    wr(8'hFF, 8'h00);

    rd_chk("R7 bus address", 8'h00);
    wr(8'h00, 8'hAA);
    rd_chk("R7 write ignored", 8'h00);
    strap = 4'hF;
    rd_chk("R7 bus address max strap", 8'h00);

    wr(8'h02, 8'h5A);
    rd_chk("R10 scratch", 8'h02);
    wr(8'h03, 8'h77);
    rd_chk("R11 reserved reads zero", 8'h03);

    wr(8'hFF, 8'hF6);
    rd_chk("R2 select upper bits zero", 8'hFF);

    wr(8'hFF, 8'h05);
    wr(8'h10, 8'h11);
    rd_chk("R5 read selected channel", 8'h10);
    wr(8'hFF, 8'h06);
    rd_chk("R3 other channel untouched", 8'h10);
    wr(8'hFF, 8'h00);
    rd_chk("R3 shared untouched", 8'h02);

    wr(8'hFF, 8'h0C);
    wr(8'h20, 8'h99);
    wr(8'h21, 8'h42);
    rd_chk("R2 select write while broadcast", 8'hFF);
    for (int c = 0; c < 4; c++) begin
      wr(8'hFF, 8'h04 | 8'(c));
      rd_chk("R4 broadcast first byte", 8'h20);
      rd_chk("R4 broadcast persists", 8'h21);
    end
    wr(8'hFF, 8'h08);
    wr(8'h30, 8'h55);
    rd_chk("R4 bit3 alone goes shared", 8'h30);
    wr(8'hFF, 8'h04);
    rd_chk("R4 bit3 alone no channel write", 8'h30);

    wr(8'hFF, 8'h00);
    rd_chk("R6 read value", 8'h02);
    hold = rdata;
    wr(8'h02, 8'h3C);
    repeat (3) @(negedge clk);
    chk("R6 hold without rd_en", rdata, hold);

    @(negedge clk); irq_evt = 4'b0101; m_irq |= 4'b0101;
    @(negedge clk); irq_evt = 4'b0000;
    rd_chk("R9 irq flags set", 8'h04);
    repeat (2) @(negedge clk);
    rd_chk("R9 irq flags sticky", 8'h04);
    wr(8'h04, 8'hFF);
    rd_chk("R9 irq write ignored", 8'h04);
    wr(8'hFF, 8'h08);
    wr(8'h01, 8'h01, 4'b1000);
    rd_chk("R9 event beats clear", 8'h04);
    rd_chk("R8 clear resets scratch", 8'h02);
    rd_chk("R8 clear resets select", 8'hFF);
    rd_chk("R8 control reads zero", 8'h01);

    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 2) wr(8'hFF, 8'($urandom_range(0, 255)));
      else if (op < 5) wr(8'($urandom_range(0, 254)), 8'($urandom_range(0, 255)),
                           ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'b0);
      else rd_chk("R5 random access", 8'($urandom_range(0, 255)));
    end

    finish_run();
  end
endmodule